// File: doc/BRIEF.md
# Fractional Clock Divider, Ratio 271/27

The block turns an input clock into a train of single-cycle pulses whose mean spacing is ten and one twenty-seventh input clocks. Every 271 input clocks it gives exactly 27 pulses. Twenty-six of the gaps are 10 clocks long and one is 11 clocks long. The division is done by two small feedback shift registers. There is no binary counter and no comparator.

The first stage is a 4-bit prescaler. Its state value reads the register as a binary number, with the input stage as bit 0 and the output stage as bit 3. It shifts left every clock: the next state is {state[2:0], d}. The feedback bit d is the inverse of bit 3, except at four states. At states 1, 9 and 2 the bit is flipped. This joins the two rings and cuts the loop to eleven states: PS00→PS01→PS02→PS04→PS09→PS03→PS07→PS15→PS14→PS12→PS08. At PS08 the feedback depends on the terminal flag of the second stage. When the flag is high, the prescaler goes back to PS00 and the lap is 11 clocks long. When the flag is low, it jumps to PS01, skips PS00, and the lap is 10 clocks long. The states left over are PS05, PS06, PS10, PS11 and PS13. They escape along PS05→PS11→PS06→PS13→PS10→PS04.

The second stage is a 5-bit register with the same left shift, so it has 27 states. It steps once per prescaler lap, in the clock that follows PS12. Its feedback is the inverse of bit 4, flipped at states 1, 17, 2, 18, 6 and 10. The first four of these flips join three rings of ten states into one ring. The flip at 6 removes states 13, 27 and 22 from the ring. The flip at 10 sends the two-state ring 10/21 into the main ring. Its terminal state is 0, and the terminal flag is brought out as an output.

Top module: `frac_div_271`

## Requirements
- R1: While reset is held, both registers are 0 and the pulse output is low. In the first cycle after reset is released, both the pulse output and the terminal flag are high.
- R2: A normal prescaler lap starts the pulse at state 1 and is 10 clocks from that pulse to the next.
- R3: When the prescaler reaches state 8 with the terminal flag high, the next lap passes through state 0 and is 11 clocks long. Counted from release, the pulses come at cycle offsets 0 and 11+10k, for k from 0 to 25, and this pattern repeats every 271 cycles.
- R4: Any 271 consecutive cycles that start at a multiple of 271 after release hold exactly 27 pulses.
- R5: Each pulse is one input clock wide. Pulses are never high on two consecutive cycles.
- R6: The terminal flag is high in cycles 0 to 9 after release. After that it is high for 11 cycles in every 271, in cycles whose offset modulo 271 is 270 or 0 to 9.
- R7: The second stage, and so the terminal flag, changes only in the cycle right after the prescaler was at state 12.
- R8: If the prescaler is put into one of its leftover states 5, 6, 10, 11 or 13, it rejoins the 11-state loop within 6 clocks. From state 5 it reaches state 4 after five steps, and the 271-cycle pulse pattern then continues.
- R9: If the second stage is put into one of its leftover states 10, 13, 21, 22 or 27, it rejoins its 27-state ring within three steps. From state 13 it reaches state 12 after three laps and then state 0 after twenty more laps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high, clears both stages |
| pulse_o | output | 1 | One-clock output pulse, 27 per 271 input clocks |
| term_o | output | 1 | High while the second stage is at its terminal state 0 |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that the registers change only through their own feedback. The one exception is a deliberate upset placed at a chosen moment. The bench holds reset for three cycles every time. It upsets the prescaler only in a cycle that does not follow state 8, and the second stage only in the cycle right after the prescaler was at state 12. The lap and stepping rules therefore never see a change that the logic itself could not have made. After each upset, the bench compares every output cycle against the 271-cycle pattern shifted by the offset that follows from the escape path.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int PRE_W = 4;
    localparam int MOD_W = 5;

    typedef enum logic [PRE_W-1:0] {
        PS00 = 4'd0,  PS01 = 4'd1,  PS02 = 4'd2,  PS03 = 4'd3,
        PS04 = 4'd4,  PS05 = 4'd5,  PS06 = 4'd6,  PS07 = 4'd7,
        PS08 = 4'd8,  PS09 = 4'd9,  PS10 = 4'd10, PS11 = 4'd11,
        PS12 = 4'd12, PS13 = 4'd13, PS14 = 4'd14, PS15 = 4'd15
    } pre_state_e;

    // Prescaler state whose carry steps the second stage
    localparam pre_state_e PRE_ENA = PS12;
    // Terminal state of the second stage
    localparam logic [MOD_W-1:0] MOD_TERM = '0;

endpackage

// File: rtl/frac_div_pre.sv
module frac_div_pre
    import frac_div_pkg::*;
#(
    parameter pre_state_e ENA_STATE = PRE_ENA
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       long_i,
    output pre_state_e state_o,
    output logic       carry_o
);

    pre_state_e state_q;
    pre_state_e state_d;
    logic       d_bit;

    // Feedback selection: twisted ring, with the merge, cut and lap-length flips
    always_comb begin
        d_bit = ~state_q[PRE_W-1];
        unique case (state_q)
            PS01, PS09: d_bit = state_q[PRE_W-1];   // join the two rings
            PS02:       d_bit = state_q[PRE_W-1];   // cut 2->4
            PS08:       d_bit = ~long_i;            // 8->0 long lap, 8->1 short lap
            default:    ;
        endcase
        state_d = pre_state_e'({state_q[PRE_W-2:0], d_bit});
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PS00;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        state_o = state_q;
        carry_o = (state_q == ENA_STATE);
    end

endmodule

// File: rtl/frac_div_mod27.sv
module frac_div_mod27
    import frac_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    output logic term_o
);

    logic [MOD_W-1:0] state_q;
    logic [MOD_W-1:0] state_d;
    logic             flip;

    always_comb begin
        unique case (state_q)
            5'd1, 5'd17: flip = 1'b1;   // join first and second ring
            5'd2, 5'd18: flip = 1'b1;   // join third ring
            5'd6:        flip = 1'b1;   // cut 6->12, dropping three states
            5'd10:       flip = 1'b1;   // send the 10/21 ring into 20
            default:     flip = 1'b0;
        endcase
        state_d = step_i ? {state_q[MOD_W-2:0], ~state_q[MOD_W-1] ^ flip} : state_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        term_o = (state_q == MOD_TERM);
    end

endmodule

// File: rtl/frac_div_271.sv
module frac_div_271
    import frac_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output logic pulse_o,
    output logic term_o
);

    pre_state_e pre_state;
    logic       carry;
    logic       term;
    logic       was_zero_q;

    frac_div_pre #(
        .ENA_STATE(PRE_ENA)
    ) u_pre (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .long_i  (term),
        .state_o (pre_state),
        .carry_o (carry)
    );

    frac_div_mod27 u_mod (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (carry),
        .term_o (term)
    );

    // One bit of history tells whether state 1 follows state 0 or state 8
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            was_zero_q <= 1'b1;
        end else begin
            was_zero_q <= (pre_state == PS00);
        end
    end

    // Outputs
    always_comb begin
        pulse_o = ~rst_i & ((pre_state == PS00) |
                            ((pre_state == PS01) & ~was_zero_q));
        term_o  = term;
    end

endmodule

// File: rtl/frac_div_271_chk.sv
module frac_div_271_chk
    import frac_div_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             pulse_i,
    input logic             term_i,
    input logic [PRE_W-1:0] pre_state_i
);

    // R5
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_i |=> !pulse_i);

    // R5
    pulse_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_i |-> (pre_state_i == 4'd0 || pre_state_i == 4'd1));

    // R2
    short_lap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pre_state_i == 4'd8 && !term_i) |=> (pre_state_i == 4'd1));

    // R3
    long_lap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pre_state_i == 4'd8 && term_i) |=> (pre_state_i == 4'd0));

    // R7
    mod_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (term_i != $past(term_i)) |-> ($past(pre_state_i) == 4'(PRE_ENA)));

endmodule

bind frac_div_271 frac_div_271_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .pulse_i     (pulse_o),
    .term_i      (term_o),
    .pre_state_i (pre_state)
);

// File: tb/frac_div_271_test.sv
module frac_div_271_test;
    import frac_div_pkg::*;

    logic clk_i = 1'b0;
    logic rst_i = 1'b1;
    logic pulse_o;
    logic term_o;
    int   runs  = 0;
    int   fails = 0;
    bit   done  = 1'b0;

    localparam int PERIOD = 271;

    frac_div_271 uut (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .pulse_o (pulse_o),
        .term_o  (term_o)
    );

    always #10 clk_i = ~clk_i;

    function automatic bit exp_pulse(int n);
        int r = n % PERIOD;
        return (r == 0) || (r >= 11 && ((r - 11) % 10) == 0);
    endfunction

    function automatic bit exp_flag(int n);
        int r = n % PERIOD;
        return (r <= 9) || (r == 270);
    endfunction

    task automatic check(string tag, int n, int act, int exp);
        runs++;
        if (act != exp) begin
            fails++;
            if (fails <= 20)
                $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, n, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk_i);
        #1;
    endtask

    // Hold reset for three cycles, release, and stop in cycle 0
    task automatic do_reset();
        @(negedge clk_i);
        rst_i = 1'b1;
        repeat (3) begin
            @(negedge clk_i);
            #1;
            check("R1 pulse low in reset", -1, int'(pulse_o), 0);
        end
        @(negedge clk_i);
        rst_i = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pulse at release", 0, int'(pulse_o), 1);
        check("R1 flag at release", 0, int'(term_o), 1);
    endtask

    task automatic t_pattern();
        bit prev = 1'b0;
        do_reset();
        for (int n = 0; n < 3 * PERIOD; n++) begin
            check("R3 pulse pattern", n, int'(pulse_o), int'(exp_pulse(n)));
            check("R6 flag pattern", n, int'(term_o), int'(exp_flag(n)));
            if (pulse_o && prev) check("R5 width", n, 1, 0);
            prev = pulse_o;
            next_cycle();
        end
    endtask

    task automatic t_intervals();
        int last = 0;
        do_reset();
        for (int n = 0; n < 3 * PERIOD; n++) begin
            if (pulse_o && n > 0) begin
                if ((last % PERIOD) == 0) check("R3 long lap", n, n - last, 11);
                else                      check("R2 short lap", n, n - last, 10);
                last = n;
            end
            next_cycle();
        end
    endtask

    task automatic t_count();
        int cnt [2] = '{0, 0};
        do_reset();
        for (int n = 0; n < 2 * PERIOD; n++) begin
            if (pulse_o) cnt[n / PERIOD]++;
            next_cycle();
        end
        check("R4 pulses first window", 0, cnt[0], 27);
        check("R4 pulses second window", PERIOD, cnt[1], 27);
    endtask

    task automatic t_step();
        do_reset();
        for (int n = 0; n <= 270; n++) begin
            if (n == 9)   check("R7 flag before first step", n, int'(term_o), 1);
            if (n == 10)  check("R7 flag after first step", n, int'(term_o), 0);
            if (n == 269) check("R7 flag before wrap", n, int'(term_o), 0);
            if (n == 270) check("R7 flag after wrap", n, int'(term_o), 1);
            next_cycle();
        end
    endtask

    task automatic t_pre_recover();
        do_reset();
        for (int n = 0; n < 2 * PERIOD + 20; n++) begin
            if (n == 2) begin
                force uut.u_pre.state_q = PS05;
                next_cycle();
                release uut.u_pre.state_q;
                n++;
            end
            if (n >= 6) begin
                check("R8 pulse after upset", n, int'(pulse_o), int'(exp_pulse(n - 5)));
                check("R8 flag after upset", n, int'(term_o), int'(exp_flag(n - 5)));
            end
            next_cycle();
        end
    endtask

    task automatic t_mod_recover();
        do_reset();
        for (int n = 0; n < 700; n++) begin
            if (n == 10) begin
                force uut.u_mod.state_q = 5'd13;
                next_cycle();
                release uut.u_mod.state_q;
                n++;
            end
            if (n >= 11) begin
                check("R9 pulse after upset", n, int'(pulse_o), int'(exp_pulse(n + 30)));
                check("R9 flag after upset", n, int'(term_o), int'(exp_flag(n + 30)));
            end
            next_cycle();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pattern();
        t_intervals();
        t_count();
        t_step();
        t_pre_recover();
        t_mod_recover();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule